// File: doc/BRIEF.md
# Programmable Asynchronous Serial Receiver

This block turns an asynchronous serial line into 8-bit characters. A small control register fixes the frame shape: 5 to 8 data bits, an optional parity bit with odd or even sense, and one or two stop bits. The register can be reloaded at run time, so one instance serves several line formats. The receiver oversamples the line with a 16x bit-rate enable. It confirms a start bit at its centre, then samples each later bit at its centre. The sampled bits are collected in a 12-bit shift register.

When the last expected stop bit has been sampled, the block moves only the valid data bits into the receive buffer, right-justified, with the unused upper bits set to zero. It checks the parity bit and the stop bits at positions that depend on the current format. The data-ready flag rises, and the parity, framing and overrun flags are refreshed at the same moment. The host reads the buffer and pulses the data-ready clear input. A character that completes before that pulse replaces the old one and raises the overrun flag.

Top module: `uart_rx_prog`

## Requirements
- R1: While reset is asserted, and after it, until the first character completes, the receive buffer, data-ready, parity-error, framing-error and overrun-error outputs are all 0.
- R2: The control word (length, parity-off, even-parity, two-stop) is captured on every clock in which the load input is high. Changes on those inputs while load is low have no effect on how frames are received.
- R3: Length code 00, 01, 10 or 11 selects 5, 6, 7 or 8 data bits, received LSB first. The buffer holds them right-justified, and every buffer bit at or above the length is 0.
- R4: A start bit is accepted only if the line, after a falling edge, is still low 8 enable ticks later. A shorter low pulse produces no character.
- R5: With parity enabled, the parity bit follows the last data bit. Even-parity = 1 expects an even number of ones over data plus parity; even-parity = 0 expects an odd number. A mismatch sets the parity-error flag for that character.
- R6: With parity-off = 1, no parity bit is in the frame, and the parity-error flag is 0 for that character.
- R7: One stop bit is checked when two-stop = 0, and two when it is 1. The framing-error flag is set when any expected stop bit is sampled as 0.
- R8: Data-ready rises when a character completes and falls one clock after a pulse on the data-ready clear input.
- R9: If a character completes while data-ready is high, the overrun flag is set, and the new character replaces the buffer contents.
- R10: The buffer and the three error flags change only when a character completes, and then all of them are updated for that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick16_i | input | 1 | Enable pulse at 16 times the bit rate |
| rx_i | input | 1 | Serial input, idle high |
| cfg_len_i | input | 2 | Data length code (00=5 .. 11=8 bits) |
| cfg_par_off_i | input | 1 | 1 = no parity bit |
| cfg_par_even_i | input | 1 | 1 = even parity, 0 = odd |
| cfg_stop2_i | input | 1 | 1 = two stop bits |
| cfg_load_i | input | 1 | Control word capture enable |
| dr_clr_i | input | 1 | Data-ready clear pulse |
| rbuf_o | output | 8 | Received character, zero-padded |
| dready_o | output | 1 | Character available |
| perr_o | output | 1 | Parity error of last character |
| ferr_o | output | 1 | Framing error of last character |
| oerr_o | output | 1 | Overrun error of last character |

## Verification
A wrong bit count or a wrong tick phase shows at the ports within one frame. Either a bad frame length shifts the buffer contents and moves the checked parity and stop positions, or a bad sampling phase produces a wrong character. Both are seen on the first character whose length, parity or stop setting differs from the previous one. A stale control word or a wrong overrun path shows at the next completion, through the error flags. Random frames therefore cover every format and inject parity and stop faults. A directed runt pulse and directed runs of back-to-back characters cover start qualification and overrun.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef struct packed {
    logic [1:0] len;
    logic       par_off;
    logic       par_even;
    logic       stop2;
  } rx_cfg_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_START = 2'd1,
    S_BITS  = 2'd2
  } rx_state_e;

endpackage

// File: rtl/rx_cfg_reg.sv
module rx_cfg_reg
  import uart_rx_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    load_i,
  input  rx_cfg_t cfg_i,
  output rx_cfg_t cfg_o
);

  rx_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (load_i) cfg_d = cfg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/rx_sampler.sv
module rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int OVS     = 16,
  parameter int FRAME_W = 12,
  parameter int SYNC    = 2,
  localparam int TW     = $clog2(OVS),
  localparam int CW     = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               rx_i,
  input  logic [CW-1:0]      nbits_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               done_o
);

  localparam int HALF = OVS / 2;

  logic [SYNC-1:0]    sync_q;
  logic               rx_s;
  rx_state_e          st_q, st_d;
  logic [TW-1:0]      tcnt_q, tcnt_d;
  logic [CW-1:0]      bidx_q, bidx_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               prev_q, prev_d;
  logic               done_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC-2:0], rx_i};
  end
  assign rx_s = sync_q[SYNC-1];

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    bidx_d = bidx_q;
    sh_d   = sh_q;
    prev_d = prev_q;
    done_d = 1'b0;
    if (tick_i) begin
      prev_d = rx_s;
      unique case (st_q)
        S_IDLE: begin
          if (prev_q && !rx_s) begin
            st_d   = S_START;
            tcnt_d = '0;
          end
        end
        S_START: begin
          if (tcnt_q == TW'(HALF - 1)) begin
            tcnt_d = '0;
            bidx_d = '0;
            st_d   = rx_s ? S_IDLE : S_BITS;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
        S_BITS: begin
          if (tcnt_q == TW'(OVS - 1)) begin
            tcnt_d = '0;
            sh_d   = {rx_s, sh_q[FRAME_W-1:1]};
            if (bidx_q == nbits_i - 1'b1) begin
              done_d = 1'b1;
              st_d   = S_IDLE;
            end else begin
              bidx_d = bidx_q + 1'b1;
            end
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      tcnt_q <= '0;
      bidx_q <= '0;
      sh_q   <= '0;
      prev_q <= 1'b1;
      done_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
      bidx_q <= bidx_d;
      sh_q   <= sh_d;
      prev_q <= prev_d;
      done_o <= done_d;
    end
  end

  assign frame_o = sh_q;

endmodule

// File: rtl/rx_check.sv
module rx_check
  import uart_rx_pkg::*;
#(
  parameter int FRAME_W = 12,
  parameter int DW      = 8,
  localparam int CW     = $clog2(FRAME_W + 1)
) (
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CW-1:0]      nbits_i,
  input  rx_cfg_t            cfg_i,
  output logic [DW-1:0]      data_o,
  output logic               perr_o,
  output logic               ferr_o
);

  logic [FRAME_W-1:0] just;
  logic [CW-1:0]      dlen, s1_pos;
  logic               pbit, s1, s2, odd;

  assign just   = frame_i >> (CW'(FRAME_W) - nbits_i);
  assign dlen   = CW'(5) + CW'(cfg_i.len);
  assign s1_pos = dlen + CW'(!cfg_i.par_off);

  for (genvar i = 0; i < DW; i++) begin : g_lane
    assign data_o[i] = (CW'(i) < dlen) ? just[i] : 1'b0;
  end

  always_comb begin
    pbit   = just[dlen];
    s1     = just[s1_pos];
    s2     = just[s1_pos + 1'b1];
    odd    = (^data_o) ^ pbit;
    perr_o = cfg_i.par_off ? 1'b0 : (cfg_i.par_even ? odd : !odd);
    ferr_o = !s1 || (cfg_i.stop2 && !s2);
  end

endmodule

// File: rtl/uart_rx_prog.sv
module uart_rx_prog
  import uart_rx_pkg::*;
#(
  parameter int OVS     = 16,
  parameter int FRAME_W = 12,
  parameter int DW      = 8,
  parameter int SYNC    = 2,
  localparam int CW     = $clog2(FRAME_W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick16_i,
  input  logic          rx_i,
  input  logic [1:0]    cfg_len_i,
  input  logic          cfg_par_off_i,
  input  logic          cfg_par_even_i,
  input  logic          cfg_stop2_i,
  input  logic          cfg_load_i,
  input  logic          dr_clr_i,
  output logic [DW-1:0] rbuf_o,
  output logic          dready_o,
  output logic          perr_o,
  output logic          ferr_o,
  output logic          oerr_o
);

  logic [1:0]         rst_sync_q;
  logic               rst_n;
  rx_cfg_t            cfg_in, cfg;
  logic [CW-1:0]      nbits;
  logic [FRAME_W-1:0] frame;
  logic               done;
  logic [DW-1:0]      data_w;
  logic               perr_w, ferr_w;

  logic [DW-1:0] rbuf_q, rbuf_d;
  logic          dr_q, dr_d, pe_q, pe_d, fe_q, fe_d, oe_q, oe_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign cfg_in = '{len: cfg_len_i, par_off: cfg_par_off_i,
                    par_even: cfg_par_even_i, stop2: cfg_stop2_i};

  rx_cfg_reg u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .load_i(cfg_load_i),
    .cfg_i (cfg_in),
    .cfg_o (cfg)
  );

  assign nbits = CW'(6) + CW'(cfg.len) + CW'(!cfg.par_off) + CW'(cfg.stop2);

  rx_sampler #(.OVS(OVS), .FRAME_W(FRAME_W), .SYNC(SYNC)) u_smp (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .tick_i (tick16_i),
    .rx_i   (rx_i),
    .nbits_i(nbits),
    .frame_o(frame),
    .done_o (done)
  );

  rx_check #(.FRAME_W(FRAME_W), .DW(DW)) u_chk (
    .frame_i(frame),
    .nbits_i(nbits),
    .cfg_i  (cfg),
    .data_o (data_w),
    .perr_o (perr_w),
    .ferr_o (ferr_w)
  );

  always_comb begin
    rbuf_d = rbuf_q;
    pe_d   = pe_q;
    fe_d   = fe_q;
    oe_d   = oe_q;
    dr_d   = dr_q;
    if (dr_clr_i) dr_d = 1'b0;
    if (done) begin
      rbuf_d = data_w;
      pe_d   = perr_w;
      fe_d   = ferr_w;
      oe_d   = dr_q && !dr_clr_i;
      dr_d   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rbuf_q <= '0;
      dr_q   <= 1'b0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      rbuf_q <= rbuf_d;
      dr_q   <= dr_d;
      pe_q   <= pe_d;
      fe_q   <= fe_d;
      oe_q   <= oe_d;
    end
  end

  assign rbuf_o   = rbuf_q;
  assign dready_o = dr_q;
  assign perr_o   = pe_q;
  assign ferr_o   = fe_q;
  assign oerr_o   = oe_q;

endmodule

// File: rtl/uart_rx_prog_chk.sv
module uart_rx_prog_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       done,
  input logic       par_off,
  input logic [1:0] len,
  input logic       dr_clr_i,
  input logic [7:0] rbuf_o,
  input logic       dready_o,
  input logic       perr_o,
  input logic       ferr_o,
  input logic       oerr_o
);

  p_dready_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> dready_o);

  p_dready_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dr_clr_i && !done) |=> !dready_o);

  p_overrun_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && dready_o && !dr_clr_i) |=> oerr_o);

  p_flags_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> $stable({rbuf_o, perr_o, ferr_o, oerr_o}));

  p_no_perr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && par_off) |=> !perr_o);

  p_pad_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && len == 2'b00) |=> rbuf_o[7:5] == 3'b000);

  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dready_o && !done |=> !dready_o || $past(done));

endmodule

bind uart_rx_prog uart_rx_prog_chk u_rx_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .done    (done),
  .par_off (cfg.par_off),
  .len     (cfg.len),
  .dr_clr_i(dr_clr_i),
  .rbuf_o  (rbuf_o),
  .dready_o(dready_o),
  .perr_o  (perr_o),
  .ferr_o  (ferr_o),
  .oerr_o  (oerr_o)
);

// File: tb/sim_uart_rx_prog.sv
`timescale 1ns/1ps
module sim_uart_rx_prog;

  localparam int TDIV = 3;
  localparam int BITC = 16 * TDIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic rx = 1'b1;
  logic [1:0] len_i = 2'b11;
  logic poff_i = 1'b1, even_i = 1'b0, stop2_i = 1'b0, load_i = 1'b0, clr_i = 1'b0;
  logic [7:0] rbuf;
  logic dready, perr, ferr, oerr;

  int n_chk = 0, n_fail = 0;
  int tdiv_cnt = 0;
  logic exp_dr = 1'b0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tdiv_cnt <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
    tick     <= (tdiv_cnt == TDIV - 1);
  end

  uart_rx_prog u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .rx_i(rx),
    .cfg_len_i(len_i), .cfg_par_off_i(poff_i), .cfg_par_even_i(even_i),
    .cfg_stop2_i(stop2_i), .cfg_load_i(load_i), .dr_clr_i(clr_i),
    .rbuf_o(rbuf), .dready_o(dready), .perr_o(perr), .ferr_o(ferr), .oerr_o(oerr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] len_mask(input logic [1:0] l);
    return 8'hFF >> (3 - l);
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input logic ev);
    return ev ? ^d : ~^d;
  endfunction

  task automatic bit_out(input logic b);
    rx = b;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic load_cfg(input logic [1:0] l, input logic po, input logic ev, input logic s2);
    @(negedge clk);
    len_i = l; poff_i = po; even_i = ev; stop2_i = s2; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    len_i = ~l; poff_i = ~po; even_i = ~ev; stop2_i = ~s2;
  endtask

  task automatic clear_dr();
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0;
    @(negedge clk);
    chk("R8 dready cleared", dready, 0);
    exp_dr = 1'b0;
  endtask

  // bad_stop: 0 none, 1 first stop low, 2 second stop low
  task automatic frame(input logic [7:0] d, input logic [1:0] l, input logic po,
                       input logic ev, input logic s2, input logic flip, input int bad_stop);
    logic [7:0] md;
    md = d & len_mask(l);
    bit_out(1'b0);
    for (int i = 0; i < 5 + int'(l); i++) bit_out(md[i]);
    if (!po) bit_out(par_bit(md, ev) ^ flip);
    bit_out(bad_stop == 1 ? 1'b0 : 1'b1);
    if (s2) bit_out(bad_stop == 2 ? 1'b0 : 1'b1);
    bit_out(1'b1);
    bit_out(1'b1);
    chk("R3 data", rbuf, md);
    chk("R8 dready set", dready, 1);
    chk("R5/R6 parity flag", perr, (!po && flip));
    chk("R7 framing flag", ferr, bad_stop != 0);
    chk("R9 overrun flag", oerr, exp_dr);
    exp_dr = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    chk("R1 rbuf reset", rbuf, 0);
    chk("R1 dready reset", dready, 0);
    chk("R1 flags reset", {perr, ferr, oerr}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 dready after release", dready, 0);

    // R3: 5-bit length pads 0xFF to 0x1F
    load_cfg(2'b00, 1'b1, 1'b0, 1'b0);
    frame(8'hFF, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 0);
    chk("R3 upper zero", rbuf[7:5], 0);
    clear_dr();

    // R4: runt low pulse of 3 ticks is not a start bit
    rx = 1'b0; repeat (3 * TDIV) @(negedge clk);
    rx = 1'b1; repeat (3 * BITC) @(negedge clk);
    chk("R4 runt ignored dready", dready, 0);
    chk("R4 runt ignored rbuf", rbuf, 8'h1F);

    // R2: inputs inverted while load low; latched 8E2 still used
    load_cfg(2'b11, 1'b0, 1'b1, 1'b1);
    frame(8'hA5, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 0);
    chk("R2 latched format", rbuf, 8'hA5);
    // R9: no clear, next frame overruns and replaces
    frame(8'h3C, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 2);
    chk("R9 replaced", rbuf, 8'h3C);
    clear_dr();

    // R6: parity off with odd-looking data
    load_cfg(2'b10, 1'b1, 1'b1, 1'b0);
    frame(8'h07, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 0);
    clear_dr();

    for (int k = 0; k < 36; k++) begin
      logic [1:0] l; logic po, ev, s2, fl; int bs; logic [7:0] d;
      l = 2'($urandom); po = 1'($urandom); ev = 1'($urandom); s2 = 1'($urandom);
      fl = 1'($urandom); d = 8'($urandom);
      bs = ($urandom % 4 == 0) ? (s2 ? 1 + int'($urandom % 2) : 1) : 0;
      load_cfg(l, po, ev, s2);
      if ($urandom % 3 != 0 && exp_dr) clear_dr();
      frame(d, l, po, ev, s2, fl, bs);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule